// File: doc/BRIEF.md
# Bus-Master Channel Control Registers

This block is the software-facing register set of one bus-master disk channel. It holds a command byte, a status byte and a 32-bit descriptor-table base, all reached through a small byte-addressed port that takes 1-, 2- and 4-byte accesses. The DMA engine beside it gets one-cycle start and stop pulses, a transfer direction, and a current-descriptor pointer. The engine advances that pointer and reports when it goes idle or hits an error.

The engine only acts on a change of the command start bit. Rewriting the value already held starts nothing and stops nothing. A rising device interrupt is latched into status and also passed straight through to the interrupt output. Software clears the latched error and interrupt flags by writing ones to them.

Top module: `bm_regfile`

## Requirements
- R1: A command write stores only bit 0 (start) and bit 3 (direction, also driven on `xfer_dir`). Every other command bit reads back as zero.
- R2: A command write whose bit 0 equals the stored start bit gives no start pulse and no stop pulse, and leaves `cur_ptr` unchanged.
- R3: A command write that changes start from 1 to 0 gives a one-cycle `eng_stop` pulse in the cycle after the write and clears status bit 0 (active).
- R4: A command write that changes start from 0 to 1 loads `cur_ptr` from the table base. If status bit 0 was clear, the write also sets it and gives a one-cycle `eng_start` pulse in the following cycle. If status bit 0 was already set, no pulse is given.
- R5: A table-base write of 1, 2 or 4 bytes (`reg_size` 0, 1, 2) at byte offset `reg_addr[1:0]` replaces only the addressed bytes, taking data from the low lanes of `reg_wdata`. Bits 1:0 of the base always read as zero.
- R6: A table-base read returns the addressed bytes moved down to the low lanes, with the unaddressed upper lanes zero.
- R7: `irq_out` follows `dev_irq` in the same cycle. A rising `dev_irq` sets status bit 2. A falling `dev_irq` leaves status unchanged.
- R8: Status bit 1 (error, set by `eng_err`) and bit 2 (interrupt) are cleared by writing 1 to them. A new set in the same cycle as a clear wins. Bit 0 ignores software writes. Bits 5 and 6 store the written value. Bits 3, 4 and 7 read zero.
- R9: An `eng_idle` pulse with `eng_more` high sets status bit 0. With `eng_more` low it clears status bit 0.
- R10: Reset clears command, status, table base and `cur_ptr`. If the channel was active, the cycle after the reset edge carries one `eng_stop` pulse.
- R11: Each `eng_step` pulse adds the descriptor size (8 bytes) to `cur_ptr`.
- R12: The command is at offset 0, status at offset 2 and the table base at offsets 4 to 7. Reads of offsets 1 and 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset of the access |
| reg_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| reg_wdata | input | 32 | Write data, low-lane aligned |
| reg_rdata | output | 32 | Read data for `reg_addr`/`reg_size`, combinational |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_stop | output | 1 | One-cycle cancel request to the engine |
| xfer_dir | output | 1 | Stored direction bit |
| cur_ptr | output | 32 | Current descriptor pointer |
| eng_idle | input | 1 | Engine went inactive |
| eng_more | input | 1 | With `eng_idle`: more data still expected |
| eng_step | input | 1 | Engine consumed one descriptor |
| eng_err | input | 1 | Engine error event |
| dev_irq | input | 1 | Device interrupt level |
| irq_out | output | 1 | Interrupt passed through to the host |

## Verification
A rising device interrupt can land in the same cycle as a software write that clears the status interrupt flag. To provoke this, the bench raises `dev_irq` on the same clock as a status write of 0x04. It then expects bit 2 to read as set, because the new event must not be lost. The bench also covers the opposite case: a clear while `dev_irq` stays high must clear the flag, since a held level is not a new edge. The error flag is driven through the same set-beats-clear ordering.

// File: rtl/bm_pkg.sv
package bm_pkg;

    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 32;
    localparam int PTR_LANES = 4;

    localparam logic [ADDR_W-1:0] CMD_OFS  = 3'd0;
    localparam logic [ADDR_W-1:0] STAT_OFS = 3'd2;

    localparam logic [7:0] CMD_KEEP = 8'h09;
    localparam int CMD_START = 0;
    localparam int CMD_DIR   = 3;

    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_IRQ  = 2;
    localparam int ST_CAP0 = 5;
    localparam int ST_CAP1 = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic       cap1;
        logic       cap0;
        logic       irq;
        logic       err;
    } stat_flags_t;

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        logic [DATA_W-1:0] m;
        case (sz)
            SZ_BYTE: m = 32'h0000_00FF;
            SZ_HALF: m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz,
                                                    input logic [1:0] ofs);
        return size_mask(sz) << {ofs, 3'b000};
    endfunction

    function automatic logic [7:0] pack_status(input logic act,
                                               input stat_flags_t f);
        logic [7:0] s;
        s          = 8'h00;
        s[ST_ACT]  = act;
        s[ST_ERR]  = f.err;
        s[ST_IRQ]  = f.irq;
        s[ST_CAP0] = f.cap0;
        s[ST_CAP1] = f.cap1;
        return s;
    endfunction

endpackage

// File: rtl/bm_tbl_ptr.sv
module bm_tbl_ptr
    import bm_pkg::*;
#(
    parameter int LANES = PTR_LANES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_hit,
    input  logic [1:0]           ofs,
    input  logic [1:0]           sz,
    input  logic [LANES*8-1:0]   wdata,
    output logic [LANES*8-1:0]   base,
    output logic [LANES*8-1:0]   rd_data
);
    localparam int W = LANES * 8;

    logic [W-1:0] wide;
    logic [W-1:0] msk;

    assign wide = wdata << {ofs, 3'b000};
    assign msk  = lane_mask(sz, ofs);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [7:0] KEEP = (i == 0) ? 8'hFC : 8'hFF;
        always_ff @(posedge clk) begin
            if (rst) begin
                base[i*8 +: 8] <= 8'h00;
            end else if (wr_hit && msk[i*8]) begin
                base[i*8 +: 8] <= wide[i*8 +: 8] & KEEP;
            end
        end
    end

    assign rd_data = (base >> {ofs, 3'b000}) & size_mask(sz);

endmodule

// File: rtl/bm_cmd_ctl.sv
module bm_cmd_ctl
    import bm_pkg::*;
#(
    parameter int PTR_W      = 32,
    parameter int DESC_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_wdata,
    input  logic [PTR_W-1:0] base,
    input  logic             eng_idle,
    input  logic             eng_more,
    input  logic             eng_step,
    output logic [7:0]       cmd_q,
    output logic             act_q,
    output logic             start_p,
    output logic             stop_p,
    output logic [PTR_W-1:0] cur_ptr
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);

    logic start_edge;
    assign start_edge = cmd_wr && (cmd_wdata[CMD_START] != cmd_q[CMD_START]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= 8'h00;
            act_q   <= 1'b0;
            start_p <= 1'b0;
            stop_p  <= act_q;
            cur_ptr <= '0;
        end else begin
            start_p <= 1'b0;
            stop_p  <= 1'b0;
            if (eng_idle) begin
                act_q <= eng_more;
            end
            if (eng_step) begin
                cur_ptr <= cur_ptr + STEP;
            end
            if (start_edge) begin
                if (!cmd_wdata[CMD_START]) begin
                    stop_p <= 1'b1;
                    act_q  <= 1'b0;
                end else begin
                    cur_ptr <= base;
                    if (!act_q) begin
                        act_q   <= 1'b1;
                        start_p <= 1'b1;
                    end
                end
            end
            if (cmd_wr) begin
                cmd_q <= cmd_wdata & CMD_KEEP;
            end
        end
    end

endmodule

// File: rtl/bm_stat_reg.sv
module bm_stat_reg
    import bm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       st_wr,
    input  logic [7:0] st_wdata,
    input  logic       dev_irq,
    input  logic       eng_err,
    input  logic       act,
    output logic [7:0] stat
);
    stat_flags_t flags;
    logic        irq_prev;
    logic        irq_rise;

    assign irq_rise = dev_irq && !irq_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            irq_prev <= 1'b0;
        end else begin
            irq_prev <= dev_irq;
            if (st_wr) begin
                if (st_wdata[ST_ERR]) flags.err <= 1'b0;
                if (st_wdata[ST_IRQ]) flags.irq <= 1'b0;
                flags.cap0 <= st_wdata[ST_CAP0];
                flags.cap1 <= st_wdata[ST_CAP1];
            end
            if (eng_err)  flags.err <= 1'b1;
            if (irq_rise) flags.irq <= 1'b1;
        end
    end

    assign stat = pack_status(act, flags);

endmodule

// File: rtl/bm_regfile.sv
module bm_regfile
    import bm_pkg::*;
#(
    parameter int DESC_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [1:0]  reg_size,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        eng_start,
    output logic        eng_stop,
    output logic        xfer_dir,
    output logic [31:0] cur_ptr,
    input  logic        eng_idle,
    input  logic        eng_more,
    input  logic        eng_step,
    input  logic        eng_err,
    input  logic        dev_irq,
    output logic        irq_out
);
    localparam int PTR_W = PTR_LANES * 8;

    logic [7:0]       cmd_q;
    logic [7:0]       stat_q;
    logic             act_q;
    logic [PTR_W-1:0] base_q;
    logic [PTR_W-1:0] ptr_rd;
    logic             cmd_wr;
    logic             st_wr;
    logic             ptr_wr;

    assign cmd_wr = reg_wr && (reg_addr == CMD_OFS);
    assign st_wr  = reg_wr && (reg_addr == STAT_OFS);
    assign ptr_wr = reg_wr && reg_addr[2];

    bm_tbl_ptr #(.LANES(PTR_LANES)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (ptr_wr),
        .ofs     (reg_addr[1:0]),
        .sz      (reg_size),
        .wdata   (reg_wdata),
        .base    (base_q),
        .rd_data (ptr_rd)
    );

    bm_cmd_ctl #(.PTR_W(PTR_W), .DESC_BYTES(DESC_BYTES)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (reg_wdata[7:0]),
        .base      (base_q),
        .eng_idle  (eng_idle),
        .eng_more  (eng_more),
        .eng_step  (eng_step),
        .cmd_q     (cmd_q),
        .act_q     (act_q),
        .start_p   (eng_start),
        .stop_p    (eng_stop),
        .cur_ptr   (cur_ptr)
    );

    bm_stat_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .st_wr    (st_wr),
        .st_wdata (reg_wdata[7:0]),
        .dev_irq  (dev_irq),
        .eng_err  (eng_err),
        .act      (act_q),
        .stat     (stat_q)
    );

    always_comb begin
        if (reg_addr[2]) begin
            reg_rdata = ptr_rd;
        end else if (reg_addr == CMD_OFS) begin
            reg_rdata = {24'h0, cmd_q};
        end else if (reg_addr == STAT_OFS) begin
            reg_rdata = {24'h0, stat_q};
        end else begin
            reg_rdata = '0;
        end
    end

    assign xfer_dir = cmd_q[CMD_DIR];
    assign irq_out  = dev_irq;

endmodule

// File: rtl/bm_regfile_chk.sv
module bm_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [7:0]  cmd_q,
    input logic [7:0]  stat_q,
    input logic [31:0] base_q,
    input logic        eng_start,
    input logic        eng_stop,
    input logic        dev_irq
);
    // R4
    start_sets_active_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (stat_q[0] && cmd_q[0]));

    // R3
    stop_clears_active_chk: assert property (@(posedge clk) disable iff (rst)
        eng_stop |-> !stat_q[0]);

    // R2
    same_start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[0] == cmd_q[0])
        |=> (!eng_start && !eng_stop));

    // R5
    ptr_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        base_q[1:0] == 2'b00);

    // R7
    irq_latch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_irq) |=> stat_q[2]);

    // R1
    cmd_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q & 8'hF6) == 8'h00);
endmodule

bind bm_regfile bm_regfile_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cmd_q     (cmd_q),
    .stat_q    (stat_q),
    .base_q    (base_q),
    .eng_start (eng_start),
    .eng_stop  (eng_stop),
    .dev_irq   (dev_irq)
);

// File: tb/sim_bm_regfile.sv
`timescale 1ns/1ps
module sim_bm_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [1:0]  reg_size = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        eng_start, eng_stop, xfer_dir, irq_out;
    logic [31:0] cur_ptr;
    logic        eng_idle = 1'b0, eng_more = 1'b0, eng_step = 1'b0;
    logic        eng_err = 1'b0, dev_irq = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bm_regfile u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_start(eng_start), .eng_stop(eng_stop), .xfer_dir(xfer_dir),
        .cur_ptr(cur_ptr), .eng_idle(eng_idle), .eng_more(eng_more),
        .eng_step(eng_step), .eng_err(eng_err), .dev_irq(dev_irq),
        .irq_out(irq_out)
    );

    typedef struct packed {
        logic        rd;
        logic [2:0]  a;
        logic [1:0]  sz;
        logic [31:0] d;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd4, 2'd2, 32'h1234_5677},
        '{1'b1, 3'd4, 2'd2, 32'h1234_5674},
        '{1'b0, 3'd5, 2'd0, 32'h0000_00AB},
        '{1'b1, 3'd5, 2'd0, 32'h0000_00AB},
        '{1'b0, 3'd6, 2'd1, 32'h0000_BEEF},
        '{1'b1, 3'd6, 2'd1, 32'h0000_BEEF},
        '{1'b0, 3'd4, 2'd0, 32'h0000_00FF},
        '{1'b1, 3'd4, 2'd2, 32'hBEEF_ABFC},
        '{1'b1, 3'd7, 2'd0, 32'h0000_00BE},
        '{1'b0, 3'd0, 2'd0, 32'h0000_00F6},
        '{1'b1, 3'd0, 2'd0, 32'h0000_0000},
        '{1'b0, 3'd0, 2'd0, 32'h0000_00FE},
        '{1'b1, 3'd0, 2'd0, 32'h0000_0008},
        '{1'b0, 3'd2, 2'd0, 32'h0000_00E0},
        '{1'b1, 3'd2, 2'd0, 32'h0000_0060}
    };

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [1:0] sz,
                      input logic [31:0] exp);
        reg_addr = a; reg_size = sz;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic idle(input logic more);
        @(negedge clk);
        eng_idle = 1'b1; eng_more = more;
        @(negedge clk);
        eng_idle = 1'b0; eng_more = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        rd("R10 cmd", 3'd0, 2'd0, 32'h0);
        rd("R10 status", 3'd2, 2'd0, 32'h0);
        rd("R10 base", 3'd4, 2'd2, 32'h0);
        chk("R10 cur_ptr", cur_ptr, 32'h0);
        chk("R10 pulses", {30'd0, eng_start, eng_stop}, 32'h0);

        // table: R1 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                @(negedge clk);
                rd($sformatf("R1 R5 R6 R8 vec%0d", i), VECS[i].a, VECS[i].sz, VECS[i].d);
            end else begin
                wr(VECS[i].a, VECS[i].sz, VECS[i].d);
            end
        end

        // R12 holes read zero
        rd("R12 ofs1", 3'd1, 2'd0, 32'h0);
        rd("R12 ofs3", 3'd3, 2'd0, 32'h0);

        // R4 start from idle
        wr(3'd0, 2'd0, 32'h01);
        chk("R4 start pulse", {31'd0, eng_start}, 32'd1);
        chk("R4 no stop", {31'd0, eng_stop}, 32'd0);
        chk("R4 cur_ptr load", cur_ptr, 32'hBEEF_ABFC);
        rd("R4 active", 3'd2, 2'd0, 32'h61);
        @(negedge clk);
        chk("R4 pulse one cycle", {31'd0, eng_start}, 32'd0);

        // R11 steps
        eng_step = 1'b1;
        @(negedge clk);
        @(negedge clk);
        eng_step = 1'b0;
        chk("R11 step", cur_ptr, 32'hBEEF_AC0C);

        // R2 rewrite same start, change dir
        wr(3'd0, 2'd0, 32'h09);
        chk("R2 quiet", {30'd0, eng_start, eng_stop}, 32'h0);
        chk("R2 cur_ptr kept", cur_ptr, 32'hBEEF_AC0C);
        chk("R1 dir", {31'd0, xfer_dir}, 32'd1);

        // R3 stop
        wr(3'd0, 2'd0, 32'h08);
        chk("R3 stop pulse", {31'd0, eng_stop}, 32'd1);
        rd("R3 inactive", 3'd2, 2'd0, 32'h60);

        // R9 idle with more
        idle(1'b1);
        rd("R9 more keeps", 3'd2, 2'd0, 32'h61);
        // R4 start while already active
        wr(3'd0, 2'd0, 32'h01);
        chk("R4 no pulse when active", {31'd0, eng_start}, 32'd0);
        chk("R4 reload when active", cur_ptr, 32'hBEEF_ABFC);
        idle(1'b0);
        rd("R9 done clears", 3'd2, 2'd0, 32'h60);

        // R8 bit0 not writable, caps stored
        wr(3'd2, 2'd0, 32'h01);
        rd("R8 act ro", 3'd2, 2'd0, 32'h00);
        @(negedge clk); eng_err = 1'b1;
        @(negedge clk); eng_err = 1'b0;
        rd("R8 err set", 3'd2, 2'd0, 32'h02);
        wr(3'd2, 2'd0, 32'h02);
        rd("R8 err w1c", 3'd2, 2'd0, 32'h00);

        // R7 interrupt
        dev_irq = 1'b1;
        #1;
        chk("R7 pass high", {31'd0, irq_out}, 32'd1);
        @(negedge clk);
        rd("R7 latch", 3'd2, 2'd0, 32'h04);
        dev_irq = 1'b0;
        #1;
        chk("R7 pass low", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        rd("R7 fall keeps", 3'd2, 2'd0, 32'h04);
        wr(3'd2, 2'd0, 32'h04);
        rd("R8 irq w1c", 3'd2, 2'd0, 32'h00);
        // R8 set beats clear in same cycle
        @(negedge clk);
        dev_irq = 1'b1;
        reg_wr = 1'b1; reg_addr = 3'd2; reg_size = 2'd0; reg_wdata = 32'h04;
        @(negedge clk);
        reg_wr = 1'b0;
        rd("R8 set wins", 3'd2, 2'd0, 32'h04);
        wr(3'd2, 2'd0, 32'h04);
        rd("R7 held level no relatch", 3'd2, 2'd0, 32'h00);
        dev_irq = 1'b0;

        // R10 reset while active
        wr(3'd0, 2'd0, 32'h00);
        wr(3'd0, 2'd0, 32'h01);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 stop on reset", {31'd0, eng_stop}, 32'd1);
        @(negedge clk);
        chk("R10 single stop", {31'd0, eng_stop}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        rd("R10 cmd clr", 3'd0, 2'd0, 32'h0);
        rd("R10 stat clr", 3'd2, 2'd0, 32'h0);
        rd("R10 base clr", 3'd4, 2'd2, 32'h0);
        chk("R10 cur clr", cur_ptr, 32'h0);

        report();
    end

endmodule